// File: doc/BRIEF.md
# Multi-Slot I2C Slave Address Matcher

This block decides whether an address seen on an I2C bus belongs to the device, and which of four own-address slots it hits. The bit-level front end captures the address and raises a one-cycle strobe. The matcher stores the address and compares it against four own-address registers in parallel, each with its own enable bit. The comparison uses either the low 7 bits or all 10 bits, as the mode flag selects. When more than one slot matches, the slot with the highest index wins. The block then reports an acknowledge decision, a one-hot slot index, and a receive or transmit flag for the winning slot.

Slot 0 differs from the others in two ways. It alone takes a don't-care mask. It alone may hand its acknowledge decision to software: in software-acknowledge mode, a slot-0 win parks the block until a software ACK or NACK pulse arrives. Bus START and STOP flags are kept apart from the matching and follow bus conditions only.

The controller has three states:
- ST_IDLE waits for an address strobe. Transition T_CAPTURE latches the address, the mode and the read/write bit, and moves to ST_EVAL.
- ST_EVAL decides in one cycle. T_NACK (no enabled slot matches) and T_AUTO (an automatic acknowledge) both return to ST_IDLE. T_DEFER (slot 0 wins while software-acknowledge mode is set) moves to ST_WAIT_SW.
- ST_WAIT_SW waits for software. T_SW_ACK and T_SW_NACK both return to ST_IDLE.

Top module: `i2c_addr_matcher`

## Requirements
- R1: An `addr_valid` strobe sampled in ST_IDLE loads `rx_addr` into `addr_capture` at that edge, whether or not a slot later matches. An automatic decision appears as a one-cycle `ack_valid` pulse at the following edge.
- R2: With `ten_bit_mode`=0, only bits 6..0 of the address and of each own address are compared. With `ten_bit_mode`=1, bits 9..0 are compared.
- R3: Slot i (own address at `own_addr[i*10 +: 10]`) takes part only while `own_en[i]`=1.
- R4: `slot_hit` is one-hot for the winning slot, with bit i standing for slot i. Slot 3 has the highest priority and slot 0 the lowest.
- R5: `addr_mask` applies to slot 0 only. A 0 in bit b makes address bit b a don't-care. An all-ones mask, within the compared width, means an exact compare.
- R6: A win by slot 1, 2 or 3 is always acknowledged automatically (`ack`=1), whatever `sw_ack_mode` is.
- R7: On an acknowledged match with `rw_bit`=0 (master writes), `rx_flag[winner]` is set. With `rw_bit`=1 (master reads), `tx_flag[winner]` is set. No other slot flag changes.
- R8: When no enabled slot matches, `ack`=0, `slot_hit`=0 and no slot flag is set.
- R9: When `sw_ack_mode`=1 and slot 0 wins, the decision edge raises `ack_pending` with `slot_hit`=0001 and no `ack_valid`. At that same edge, `tx_flag[0]` is set if `rw_bit` was 1.
- R10: In ST_WAIT_SW, `sw_ack_pulse` gives `ack_valid` with `ack`=1 and sets `rx_flag[0]` for a write. `sw_nack_pulse` gives `ack_valid` with `ack`=0 and `slot_hit`=0, and clears the `tx_flag[0]` set for a read. ACK wins if both pulses are present. `addr_valid` is ignored while pending.
- R11: `bus_start` and `bus_stop` set `start_flag` and `stop_flag` at the next edge in any state, regardless of any match.
- R12: `clr_flags` clears all slot, start and stop flags at the next edge. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | One-cycle strobe: a received address is present |
| rx_addr | input | 10 | Received address, right-aligned |
| ten_bit_mode | input | 1 | 1 = 10-bit compare, 0 = 7-bit compare |
| rw_bit | input | 1 | Direction bit: 1 = master reads, 0 = master writes |
| own_addr | input | 40 | Four own addresses, slot i at bits i*10+9..i*10 |
| own_en | input | 4 | Per-slot enable |
| addr_mask | input | 10 | Slot-0 mask, 0 = don't-care bit |
| sw_ack_mode | input | 1 | Slot-0 decision taken by software |
| sw_ack_pulse | input | 1 | Software acknowledges the pending address |
| sw_nack_pulse | input | 1 | Software declines the pending address |
| bus_start | input | 1 | START condition seen |
| bus_stop | input | 1 | STOP condition seen |
| clr_flags | input | 1 | Clear all flags |
| ack_valid | output | 1 | One-cycle pulse: `ack` holds a new decision |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledged |
| ack_pending | output | 1 | Waiting for a software decision |
| slot_hit | output | 4 | One-hot winning slot |
| rx_flag | output | 4 | Per-slot receive flags |
| tx_flag | output | 4 | Per-slot transmit flags |
| start_flag | output | 1 | START seen flag |
| stop_flag | output | 1 | STOP seen flag |
| addr_capture | output | 10 | Last captured address |

## Verification
The address is captured one edge after the strobe. An automatic decision, together with its slot index and flag, follows at the second edge. A software decision follows one edge after the pulse. START, STOP and clear affect the flags at the very next edge. A behavioural model in the bench advances on the same edges from the same sampled inputs. Every output is compared against it at each falling edge, half a cycle after the edge on which it changes. Directed checks sample at the falling edge right after the decision edge, where the `ack_valid` pulse is still visible.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_EVAL    = 2'd1,
        ST_WAIT_SW = 2'd2
    } am_state_e;

    typedef enum logic [2:0] {
        DEC_NONE    = 3'd0,
        DEC_NACK    = 3'd1,
        DEC_AUTO    = 3'd2,
        DEC_DEFER   = 3'd3,
        DEC_SW_ACK  = 3'd4,
        DEC_SW_NACK = 3'd5
    } am_dec_e;

endpackage

// File: rtl/i2c_am_slot_cmp.sv
module i2c_am_slot_cmp #(
    parameter int ADDR_W  = 10,
    parameter int SHORT_W = 7
) (
    input  logic [ADDR_W-1:0] own,
    input  logic              en,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ADDR_W-1:0] rx,
    input  logic              ten_bit,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] SHORT_SEL = {{(ADDR_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
    localparam logic [ADDR_W-1:0] LONG_SEL  = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] width_sel;
    logic              mask_active;
    logic [ADDR_W-1:0] eff_mask;
    logic [ADDR_W-1:0] care;

    always_comb begin
        width_sel   = ten_bit ? LONG_SEL : SHORT_SEL;
        mask_active = ~&(mask | ~width_sel);
        eff_mask    = mask_active ? mask : LONG_SEL;
        care        = width_sel & eff_mask;
        hit         = en && (((own ^ rx) & care) == '0);
    end
endmodule

// File: rtl/i2c_am_prio.sv
module i2c_am_prio #(
    parameter int NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0] hits,
    output logic [NUM_SLOTS-1:0] winner,
    output logic                 any_hit
);
    always_comb begin
        winner = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hits[i]) begin
                winner    = '0;
                winner[i] = 1'b1;
            end
        end
        any_hit = |hits;
    end
endmodule

// File: rtl/i2c_am_flags.sv
module i2c_am_flags #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NUM_SLOTS-1:0] set_rx,
    input  logic [NUM_SLOTS-1:0] set_tx,
    input  logic [NUM_SLOTS-1:0] drop_tx,
    input  logic                 bus_start,
    input  logic                 bus_stop,
    output logic [NUM_SLOTS-1:0] rx_flag,
    output logic [NUM_SLOTS-1:0] tx_flag,
    output logic                 start_flag,
    output logic                 stop_flag
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rx_flag[g] <= 1'b0;
                tx_flag[g] <= 1'b0;
            end else begin
                rx_flag[g] <= set_rx[g] | (rx_flag[g] & ~clr);
                tx_flag[g] <= set_tx[g] | (tx_flag[g] & ~clr & ~drop_tx[g]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b0;
        end else begin
            start_flag <= bus_start | (start_flag & ~clr);
            stop_flag  <= bus_stop  | (stop_flag  & ~clr);
        end
    end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2c_am_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 10,
    parameter int SHORT_W   = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        addr_valid,
    input  logic [ADDR_W-1:0]           rx_addr,
    input  logic                        ten_bit_mode,
    input  logic                        rw_bit,
    input  logic [NUM_SLOTS*ADDR_W-1:0] own_addr,
    input  logic [NUM_SLOTS-1:0]        own_en,
    input  logic [ADDR_W-1:0]           addr_mask,
    input  logic                        sw_ack_mode,
    input  logic                        sw_ack_pulse,
    input  logic                        sw_nack_pulse,
    input  logic                        bus_start,
    input  logic                        bus_stop,
    input  logic                        clr_flags,
    output logic                        ack_valid,
    output logic                        ack,
    output logic                        ack_pending,
    output logic [NUM_SLOTS-1:0]        slot_hit,
    output logic [NUM_SLOTS-1:0]        rx_flag,
    output logic [NUM_SLOTS-1:0]        tx_flag,
    output logic                        start_flag,
    output logic                        stop_flag,
    output logic [ADDR_W-1:0]           addr_capture
);
    localparam logic [ADDR_W-1:0] NO_MASK = {ADDR_W{1'b1}};

    am_state_e             state_q, state_d;
    am_dec_e               dec;
    logic                  ten_q, rw_q;
    logic [NUM_SLOTS-1:0]  hits, winner;
    logic                  any_hit;
    logic [NUM_SLOTS-1:0]  set_rx, set_tx, drop_tx;

    // Parallel comparators: only slot 0 sees the mask register.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        logic [ADDR_W-1:0] slot_mask;
        if (g == 0) begin : g_masked
            assign slot_mask = addr_mask;
        end else begin : g_exact
            assign slot_mask = NO_MASK;
        end
        i2c_am_slot_cmp #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_cmp (
            .own     (own_addr[g*ADDR_W +: ADDR_W]),
            .en      (own_en[g]),
            .mask    (slot_mask),
            .rx      (addr_capture),
            .ten_bit (ten_q),
            .hit     (hits[g])
        );
    end

    i2c_am_prio #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
        .hits    (hits),
        .winner  (winner),
        .any_hit (any_hit)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and decision decode.
    always_comb begin
        state_d = state_q;
        dec     = DEC_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_valid) state_d = ST_EVAL;              // T_CAPTURE
            end
            ST_EVAL: begin
                if (!any_hit)                      dec = DEC_NACK;  // T_NACK
                else if (winner[0] && sw_ack_mode) dec = DEC_DEFER; // T_DEFER
                else                               dec = DEC_AUTO;  // T_AUTO
                state_d = (dec == DEC_DEFER) ? ST_WAIT_SW : ST_IDLE;
            end
            ST_WAIT_SW: begin
                if (sw_ack_pulse) begin                          // T_SW_ACK
                    dec     = DEC_SW_ACK;
                    state_d = ST_IDLE;
                end else if (sw_nack_pulse) begin                // T_SW_NACK
                    dec     = DEC_SW_NACK;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Flag strobes derived from the decision.
    always_comb begin
        set_rx  = '0;
        set_tx  = '0;
        drop_tx = '0;
        unique case (dec)
            DEC_AUTO: begin
                if (rw_q) set_tx = winner;
                else      set_rx = winner;
            end
            DEC_DEFER: begin
                if (rw_q) set_tx = winner;
            end
            DEC_SW_ACK: begin
                if (!rw_q) set_rx = slot_hit;
            end
            DEC_SW_NACK: begin
                if (rw_q) drop_tx = slot_hit;
            end
            DEC_NONE, DEC_NACK: ;
            default: ;
        endcase
    end

    // Output register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid    <= 1'b0;
            ack          <= 1'b0;
            ack_pending  <= 1'b0;
            slot_hit     <= '0;
            addr_capture <= '0;
            ten_q        <= 1'b0;
            rw_q         <= 1'b0;
        end else begin
            ack_valid <= 1'b0;
            if (state_q == ST_IDLE && addr_valid) begin
                addr_capture <= rx_addr;
                ten_q        <= ten_bit_mode;
                rw_q         <= rw_bit;
            end
            unique case (dec)
                DEC_NACK: begin
                    ack_valid <= 1'b1;
                    ack       <= 1'b0;
                    slot_hit  <= '0;
                end
                DEC_AUTO: begin
                    ack_valid <= 1'b1;
                    ack       <= 1'b1;
                    slot_hit  <= winner;
                end
                DEC_DEFER: begin
                    ack_pending <= 1'b1;
                    ack         <= 1'b0;
                    slot_hit    <= winner;
                end
                DEC_SW_ACK: begin
                    ack_valid   <= 1'b1;
                    ack         <= 1'b1;
                    ack_pending <= 1'b0;
                end
                DEC_SW_NACK: begin
                    ack_valid   <= 1'b1;
                    ack         <= 1'b0;
                    ack_pending <= 1'b0;
                    slot_hit    <= '0;
                end
                DEC_NONE: ;
                default: ;
            endcase
        end
    end

    i2c_am_flags #(.NUM_SLOTS(NUM_SLOTS)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_flags),
        .set_rx     (set_rx),
        .set_tx     (set_tx),
        .drop_tx    (drop_tx),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .rx_flag    (rx_flag),
        .tx_flag    (tx_flag),
        .start_flag (start_flag),
        .stop_flag  (stop_flag)
    );
endmodule

// File: rtl/i2c_am_checker.sv
module i2c_am_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 addr_valid,
    input logic                 sw_ack_pulse,
    input logic                 bus_start,
    input logic                 bus_stop,
    input logic                 clr_flags,
    input logic                 ack_valid,
    input logic                 ack,
    input logic                 ack_pending,
    input logic [NUM_SLOTS-1:0] slot_hit,
    input logic                 start_flag,
    input logic                 stop_flag,
    input logic [ADDR_W-1:0]    addr_capture
);
    p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hit));

    p_upper_slots_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && (|slot_hit[NUM_SLOTS-1:1])) |-> ack);

    p_nack_no_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack) |-> (slot_hit == '0));

    p_pending_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pending |-> !ack_valid);

    p_sw_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pending && sw_ack_pulse) |=> (ack_valid && ack && !ack_pending));

    p_hold_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pending && addr_valid) |=> $stable(addr_capture));

    p_start_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> start_flag);

    p_stop_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> stop_flag);

    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flags && !bus_start) |=> !start_flag);
endmodule

bind i2c_addr_matcher i2c_am_checker #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_valid   (addr_valid),
    .sw_ack_pulse (sw_ack_pulse),
    .bus_start    (bus_start),
    .bus_stop     (bus_stop),
    .clr_flags    (clr_flags),
    .ack_valid    (ack_valid),
    .ack          (ack),
    .ack_pending  (ack_pending),
    .slot_hit     (slot_hit),
    .start_flag   (start_flag),
    .stop_flag    (stop_flag),
    .addr_capture (addr_capture)
);

// File: tb/tb_i2c_addr_matcher.sv
`timescale 1ns/1ps
module tb_i2c_addr_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 0, ten_bit_mode = 0, rw_bit = 0;
    logic [9:0]  rx_addr = '0;
    logic [39:0] own_addr = '0;
    logic [3:0]  own_en = '0;
    logic [9:0]  addr_mask = 10'h3FF;
    logic        sw_ack_mode = 0, sw_ack_pulse = 0, sw_nack_pulse = 0;
    logic        bus_start = 0, bus_stop = 0, clr_flags = 0;
    logic        ack_valid, ack, ack_pending, start_flag, stop_flag;
    logic [3:0]  slot_hit, rx_flag, tx_flag;
    logic [9:0]  addr_capture;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    i2c_addr_matcher dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_state;
    logic [9:0] m_cap;
    logic       m_rw, m_ten, m_ackv, m_ack, m_pend, m_st, m_sp;
    logic [3:0] m_hit, m_rx, m_tx;

    function automatic int model_winner();
        int w = m_ten ? 10 : 7;
        bit mask_on = 0;
        for (int b = 0; b < w; b++) if (!addr_mask[b]) mask_on = 1;
        for (int i = 3; i >= 0; i--) begin
            bit ok = own_en[i];
            for (int b = 0; b < w; b++) begin
                if (i == 0 && mask_on && !addr_mask[b]) continue;
                if (own_addr[i*10 + b] != m_cap[b]) ok = 0;
            end
            if (ok) return i;
        end
        return -1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0; m_cap <= '0; m_rw <= 0; m_ten <= 0;
            m_ackv <= 0; m_ack <= 0; m_pend <= 0; m_hit <= '0;
            m_rx <= '0; m_tx <= '0; m_st <= 0; m_sp <= 0;
        end else begin
            int win;
            logic [3:0] rx_n, tx_n;
            rx_n = clr_flags ? 4'h0 : m_rx;
            tx_n = clr_flags ? 4'h0 : m_tx;
            m_ackv <= 0;
            case (m_state)
                0: if (addr_valid) begin
                    m_cap <= rx_addr; m_rw <= rw_bit; m_ten <= ten_bit_mode; m_state <= 1;
                end
                1: begin
                    win = model_winner();
                    m_state <= 0;
                    if (win < 0) begin
                        m_ackv <= 1; m_ack <= 0; m_hit <= '0;
                    end else if (win == 0 && sw_ack_mode) begin
                        m_pend <= 1; m_ack <= 0; m_hit <= 4'b0001; m_state <= 2;
                        if (m_rw) tx_n[0] = 1;
                    end else begin
                        m_ackv <= 1; m_ack <= 1; m_hit <= 4'(1 << win);
                        if (m_rw) tx_n[win] = 1; else rx_n[win] = 1;
                    end
                end
                default: begin
                    if (sw_ack_pulse) begin
                        m_ackv <= 1; m_ack <= 1; m_pend <= 0; m_state <= 0;
                        if (!m_rw) rx_n[0] = 1;
                    end else if (sw_nack_pulse) begin
                        m_ackv <= 1; m_ack <= 0; m_pend <= 0; m_hit <= '0; m_state <= 0;
                        if (m_rw) tx_n[0] = 0;
                    end
                end
            endcase
            m_rx <= rx_n;
            m_tx <= tx_n;
            m_st <= bus_start | (m_st & ~clr_flags);
            m_sp <= bus_stop  | (m_sp & ~clr_flags);
        end
    end

    // Compare every cycle, half a period after the updating edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 ack_valid vs model",    32'(ack_valid),    32'(m_ackv));
            chk("R1 addr_capture vs model", 32'(addr_capture), 32'(m_cap));
            chk("R6 ack vs model",          32'(ack),          32'(m_ack));
            chk("R4 slot_hit vs model",     32'(slot_hit),     32'(m_hit));
            chk("R9 ack_pending vs model",  32'(ack_pending),  32'(m_pend));
            chk("R7 rx_flag vs model",      32'(rx_flag),      32'(m_rx));
            chk("R7 tx_flag vs model",      32'(tx_flag),      32'(m_tx));
            chk("R11 start_flag vs model",  32'(start_flag),   32'(m_st));
            chk("R11 stop_flag vs model",   32'(stop_flag),    32'(m_sp));
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(negedge clk);
    endtask

    // Strobe an address; return at the falling edge after the decision edge.
    task automatic probe(logic [9:0] a, logic ten, logic rw);
        cyc();
        addr_valid = 1; rx_addr = a; ten_bit_mode = ten; rw_bit = rw;
        cyc();
        addr_valid = 0;
        cyc();
    endtask

    task automatic clear_all();
        cyc(); clr_flags = 1;
        cyc(); clr_flags = 0;
    endtask

    bit done = 0;

    initial begin
        own_addr = {10'h078, 10'h056, 10'h034, 10'h012};
        own_en   = 4'hF;
        repeat (3) cyc();
        chk("R8 reset ack", 32'(ack), 0);
        chk("R4 reset slot_hit", 32'(slot_hit), 0);
        rst_n = 1;

        // R6/R7: slot 1, write
        probe(10'h034, 0, 0);
        chk("R1 ack_valid pulse", 32'(ack_valid), 1);
        chk("R6 slot1 ack", 32'(ack), 1);
        chk("R4 slot1 hit", 32'(slot_hit), 32'h2);
        chk("R7 rx_flag slot1", 32'(rx_flag), 32'h2);
        cyc();
        chk("R1 ack_valid one cycle", 32'(ack_valid), 0);

        // R7: slot 2, read
        probe(10'h056, 0, 1);
        chk("R7 tx_flag slot2", 32'(tx_flag), 32'h4);
        chk("R7 rx_flag unchanged", 32'(rx_flag), 32'h2);

        // R8: no match, flags untouched, capture still updated
        probe(10'h07F, 0, 0);
        chk("R8 nack", 32'(ack), 0);
        chk("R8 slot_hit zero", 32'(slot_hit), 0);
        chk("R8 flags unchanged", 32'({rx_flag, tx_flag}), 32'h24);
        chk("R1 capture on miss", 32'(addr_capture), 32'h07F);

        // R3: disabled slot does not match
        own_en = 4'b1011;
        probe(10'h056, 0, 0);
        chk("R3 disabled slot nack", 32'(ack), 0);
        own_en = 4'hF;

        // R4: slot 3 beats slot 1
        own_addr[39:30] = 10'h034;
        probe(10'h034, 0, 1);
        chk("R4 priority slot3", 32'(slot_hit), 32'h8);
        own_addr[39:30] = 10'h078;

        // R2: 7-bit ignores upper bits, 10-bit does not
        own_addr[19:10] = 10'h234;
        probe(10'h334, 0, 0);
        chk("R2 7-bit match", 32'(slot_hit), 32'h2);
        probe(10'h334, 1, 0);
        chk("R2 10-bit miss", 32'(ack), 0);
        own_addr[29:20] = 10'h2A5;
        probe(10'h2A5, 1, 0);
        chk("R2 10-bit match", 32'(slot_hit), 32'h4);

        // R5: mask on slot 0 only
        addr_mask = 10'h3FC;
        probe(10'h013, 0, 0);
        chk("R5 masked slot0 hit", 32'(slot_hit), 32'h1);
        chk("R5 masked slot0 ack", 32'(ack), 1);
        own_addr[19:10] = 10'h034;
        probe(10'h037, 0, 0);
        chk("R5 mask not on slot1", 32'(ack), 0);
        addr_mask = 10'h3FF;
        probe(10'h013, 0, 0);
        chk("R5 all-ones exact", 32'(ack), 0);

        // R12: clear, and set beats clear
        cyc(); bus_start = 1; bus_stop = 1;
        cyc(); bus_start = 0; bus_stop = 0;
        chk("R11 start set", 32'(start_flag), 1);
        chk("R11 stop set", 32'(stop_flag), 1);
        clear_all();
        chk("R12 flags cleared", 32'({rx_flag, tx_flag, start_flag, stop_flag}), 0);
        cyc(); bus_start = 1; clr_flags = 1;
        cyc(); bus_start = 0; clr_flags = 0;
        chk("R12 set wins", 32'(start_flag), 1);

        // R9/R10: software mode, read, then NACK; strobe ignored while pending
        sw_ack_mode = 1;
        probe(10'h012, 0, 1);
        chk("R9 pending", 32'(ack_pending), 1);
        chk("R9 no ack_valid", 32'(ack_valid), 0);
        chk("R9 slot0 hit", 32'(slot_hit), 32'h1);
        chk("R9 tx_flag early", 32'(tx_flag[0]), 1);
        probe(10'h034, 0, 0);
        chk("R10 strobe ignored", 32'(addr_capture), 32'h012);
        chk("R10 still pending", 32'(ack_pending), 1);
        cyc(); sw_nack_pulse = 1;
        cyc(); sw_nack_pulse = 0;
        chk("R10 nack valid", 32'(ack_valid), 1);
        chk("R10 nack value", 32'(ack), 0);
        chk("R10 tx_flag dropped", 32'(tx_flag[0]), 0);

        // R10: software ACK of a write, both pulses -> ACK
        probe(10'h012, 0, 0);
        cyc(); sw_ack_pulse = 1; sw_nack_pulse = 1;
        cyc(); sw_ack_pulse = 0; sw_nack_pulse = 0;
        chk("R10 ack wins", 32'(ack), 1);
        chk("R10 rx_flag slot0", 32'(rx_flag[0]), 1);

        // R6: upper slot stays automatic in software mode
        probe(10'h034, 0, 0);
        chk("R6 auto in sw mode", 32'({ack_valid, ack}), 32'h3);
        sw_ack_mode = 0;

        repeat (3) cyc();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule